// File: doc/BRIEF.md
# Ping-Pong Rectangular Block Interleaver

The block scatters the symbols of each fixed-size frame across a two-dimensional matrix so that a burst of channel errors turns into isolated errors once the receiver restores the order. Single-bit symbols arrive with a valid qualifier and an optional frame-start marker. Each frame fills a matrix of ROWS x COLS locations (16 x 24 = 384 by default) in one traversal order and is then read back in the transposed order.

Two matrix pages alternate. While the writer fills one page with the current frame, the reader empties the page holding the previous frame. The pages change roles the moment the last symbol of a frame is stored, so frames can stream back to back at one symbol per clock without a gap at the output. A mode input selects the inverse mapping, so the same block restores the original order at the receiving end. Symbols never move from one frame into another.

Top module: `ilv_pingpong`

## Requirements
- R1: Every complete frame of ROWS*COLS accepted symbols (an accepted symbol is one with in_valid high) produces exactly ROWS*COLS output symbols. An incomplete frame produces none.
- R2: With deint_mode = 0, output symbol j of a frame equals input symbol k = (j mod COLS)*ROWS + floor(j / COLS) of that frame. The symbols go in column by column and come out row by row.
- R3: With deint_mode = 1, output symbol j equals input symbol k = (j mod ROWS)*COLS + floor(j / ROWS). This is the inverse of the R2 mapping. deint_mode is held constant for a frame and its readout.
- R4: out_valid rises for the first symbol of a frame one clock cycle after the clock edge that accepts the frame's last symbol.
- R5: Writing a frame overlaps the readout of the previous one. When frames arrive at one symbol per cycle, the output runs without a gap from one frame into the next.
- R6: Once a frame's readout has started, out_valid stays high for exactly ROWS*COLS consecutive cycles. out_sof is high with the first of them only.
- R7: After reset, out_valid stays low until a first complete frame has been written.
- R8: An accepted symbol with in_sof = 1 that arrives when the write position is not at the start of a frame makes frame_err high for one cycle, in the cycle after the edge that accepts it. That symbol becomes symbol 0 of a new frame, and the partial frame is dropped.
- R9: A synchronous active-high rst clears out_valid, out_sof and frame_err and returns both pages to the idle, empty state.
- R10: in_sof on symbol 0 of a frame raises no error. in_sym and in_sof have no effect while in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| deint_mode | input | 1 | 0: interleave, 1: de-interleave |
| in_sym | input | 1 | Input symbol |
| in_valid | input | 1 | Input symbol qualifier |
| in_sof | input | 1 | Marks the accompanying symbol as symbol 0 of a frame |
| out_sym | output | 1 | Output symbol |
| out_valid | output | 1 | Output symbol qualifier |
| out_sof | output | 1 | High with the first output symbol of a frame |
| frame_err | output | 1 | One-cycle pulse on a premature frame start |

## Verification
Two events can fall in the same cycle: the page swap caused by the last write of a frame, and the final read of the previous frame. The bench provokes this by sending frames back to back with a valid symbol on every cycle. On each such swap, the new readout has to start in the cycle right after the last old symbol. The bench judges this by comparing every output symbol against the index mapping computed independently from the requirements, and by checking the cycle on which each out_sof appears against the cycle on which the frame completed.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Traversal order of a ROWS x COLS page stored row-major.
  typedef enum logic {
    SCAN_ROW_FIRST = 1'b0,  // walk along a row, then step to the next row
    SCAN_COL_FIRST = 1'b1   // walk down a column, then step to the next column
  } scan_order_e;

endpackage

// File: rtl/ilv_scan.sv
module ilv_scan
  import ilv_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 24,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int AW = $clog2(ROWS * COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  scan_order_e   order,
  input  logic          step,
  input  logic          restart,
  output logic [AW-1:0] addr,
  output logic          at_origin,
  output logic          at_end
);

  logic [RW-1:0] row_q, row_e, row_n;
  logic [CW-1:0] col_q, col_e, col_n;
  logic          row_max, col_max;

  // A restart makes the current position read as the origin.
  always_comb begin
    row_e   = restart ? '0 : row_q;
    col_e   = restart ? '0 : col_q;
    row_max = (row_e == RW'(ROWS - 1));
    col_max = (col_e == CW'(COLS - 1));
    row_n   = row_e;
    col_n   = col_e;
    if (order == SCAN_COL_FIRST) begin
      if (row_max) begin
        row_n = '0;
        col_n = col_max ? '0 : col_e + 1'b1;
      end else begin
        row_n = row_e + 1'b1;
      end
    end else begin
      if (col_max) begin
        col_n = '0;
        row_n = row_max ? '0 : row_e + 1'b1;
      end else begin
        col_n = col_e + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
    end else if (step) begin
      row_q <= row_n;
      col_q <= col_n;
    end else if (restart) begin
      row_q <= '0;
      col_q <= '0;
    end
  end

  assign addr      = AW'(row_e) * AW'(COLS) + AW'(col_e);
  assign at_end    = row_max && col_max;
  assign at_origin = (row_q == '0) && (col_q == '0);

  // R1: a step from the final location lands back on the origin
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (step && !restart && at_end) |=> at_origin);

endmodule

// File: rtl/ilv_page_ram.sv
module ilv_page_ram #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wpage,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic          re,
  input  logic          rpage,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);

  localparam int WORDS = 2 ** (AW + 1);

  logic mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[{wpage, waddr}] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[{rpage, raddr}];
  end

  // R5: the filling page and the draining page are never the same one
  p_page_split_r5: assert property (@(posedge clk)
    (we && re) |-> (wpage != rpage));

endmodule

// File: rtl/ilv_rd_seq.sv
module ilv_rd_seq
  import ilv_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 24,
  localparam int AW = $clog2(ROWS * COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_page,
  input  scan_order_e   start_order,
  output logic          rd_en,
  output logic          rd_page,
  output logic [AW-1:0] rd_addr,
  output logic          rd_first,
  output logic          rd_last
);

  logic        active_q;
  logic        page_q;
  scan_order_e order_q;
  logic        at_origin, at_end;

  ilv_scan #(.ROWS(ROWS), .COLS(COLS)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .order    (order_q),
    .step     (active_q),
    .restart  (1'b0),
    .addr     (rd_addr),
    .at_origin(at_origin),
    .at_end   (at_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      page_q   <= 1'b0;
      order_q  <= SCAN_ROW_FIRST;
    end else if (start) begin
      active_q <= 1'b1;
      page_q   <= start_page;
      order_q  <= start_order;
    end else if (rd_last) begin
      active_q <= 1'b0;
    end
  end

  assign rd_en    = active_q;
  assign rd_page  = page_q;
  assign rd_first = active_q && at_origin;
  assign rd_last  = active_q && at_end;

  // R5: a new page is only handed over when the reader is idle or on its final read
  p_start_idle_r5: assert property (@(posedge clk) disable iff (rst)
    start |-> (!active_q || rd_last));

  // R4: the cycle after a hand-over reads the first location of the page
  p_launch_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> (rd_en && rd_first));

endmodule

// File: rtl/ilv_pingpong.sv
module ilv_pingpong
  import ilv_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic deint_mode,
  input  logic in_sym,
  input  logic in_valid,
  input  logic in_sof,
  output logic out_sym,
  output logic out_valid,
  output logic out_sof,
  output logic frame_err
);

  localparam int DEPTH = ROWS * COLS;
  localparam int AW    = $clog2(DEPTH);

  scan_order_e   wr_order, rd_order;
  logic [AW-1:0] wr_addr, rd_addr;
  logic          wr_at_origin, wr_at_end;
  logic          restart, early, swap;
  logic          wr_page_q, filled_q, err_q;
  logic          rd_en, rd_page, rd_first, rd_last;
  logic          ram_q, valid_q, sof_q;
  logic [AW:0]   vcnt_q;

  // Interleave: fill column by column, drain row by row; de-interleave swaps them.
  assign wr_order = deint_mode ? SCAN_ROW_FIRST : SCAN_COL_FIRST;
  assign rd_order = deint_mode ? SCAN_COL_FIRST : SCAN_ROW_FIRST;

  assign restart = in_valid && in_sof;
  assign early   = restart && !wr_at_origin;
  assign swap    = in_valid && wr_at_end;

  ilv_scan #(.ROWS(ROWS), .COLS(COLS)) u_wr_scan (
    .clk      (clk),
    .rst      (rst),
    .order    (wr_order),
    .step     (in_valid),
    .restart  (restart),
    .addr     (wr_addr),
    .at_origin(wr_at_origin),
    .at_end   (wr_at_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_page_q <= 1'b0;
      filled_q  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= early;
      if (swap) begin
        wr_page_q <= ~wr_page_q;
        filled_q  <= 1'b1;
      end
    end
  end

  ilv_rd_seq #(.ROWS(ROWS), .COLS(COLS)) u_rd_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (swap),
    .start_page (wr_page_q),
    .start_order(rd_order),
    .rd_en      (rd_en),
    .rd_page    (rd_page),
    .rd_addr    (rd_addr),
    .rd_first   (rd_first),
    .rd_last    (rd_last)
  );

  ilv_page_ram #(.AW(AW)) u_ram (
    .clk  (clk),
    .we   (in_valid),
    .wpage(wr_page_q),
    .waddr(wr_addr),
    .wdata(in_sym),
    .re   (rd_en),
    .rpage(rd_page),
    .raddr(rd_addr),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      sof_q   <= 1'b0;
    end else begin
      valid_q <= rd_en;
      sof_q   <= rd_first;
    end
  end

  // Output-side run counter used only by the checks below.
  always_ff @(posedge clk) begin
    if (rst)          vcnt_q <= '0;
    else if (valid_q) vcnt_q <= sof_q ? (AW+1)'(1) : vcnt_q + 1'b1;
  end

  assign out_sym   = ram_q;
  assign out_valid = valid_q;
  assign out_sof   = sof_q;
  assign frame_err = err_q;

  // R8: an error pulse is always caused by an accepted frame start one cycle earlier
  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> $past(in_valid && in_sof));

  // R7: nothing leaves the block before a first page has been filled
  p_no_early_out_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> filled_q);

  // R6: a frame marker only ever appears with a valid symbol
  p_sof_valid_r6: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);

  // R6: a new frame marker comes only after a full run of symbols
  p_sof_count_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sof) |-> (vcnt_q == '0 || vcnt_q == (AW+1)'(DEPTH)));

  // R6: between markers the run stays inside one frame
  p_mid_count_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sof) |-> (vcnt_q != '0 && vcnt_q < (AW+1)'(DEPTH)));

  // R6: the output only goes quiet at the end of a complete frame
  p_gap_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> (vcnt_q == (AW+1)'(DEPTH)));

endmodule

// File: tb/tb_ilv_pingpong.sv
module tb_ilv_pingpong;

  localparam int ROWS  = 16;
  localparam int COLS  = 24;
  localparam int DEPTH = ROWS * COLS;

  logic clk = 1'b0;
  logic rst, deint_mode, in_sym, in_valid, in_sof;
  logic out_sym, out_valid, out_sof, frame_err;

  always #4 clk = ~clk;  // 125 MHz

  ilv_pingpong #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk(clk), .rst(rst), .deint_mode(deint_mode),
    .in_sym(in_sym), .in_valid(in_valid), .in_sof(in_sof),
    .out_sym(out_sym), .out_valid(out_valid), .out_sof(out_sof),
    .frame_err(frame_err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Bench-side model of the frame being written
  bit   cur [DEPTH];
  int   kidx = 0;
  bit   lfsr_bit;
  logic [15:0] lfsr = 16'hACE1;

  bit exp_sym_q [$];
  bit exp_sof_q [$];
  bit exp_mode_q[$];
  int exp_cyc_q [$];
  int out_idx = 0;

  task automatic check_bit(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // Expected readout of a completed frame, from the index mappings of R2 / R3
  task automatic push_expected();
    for (int j = 0; j < DEPTH; j++) begin
      int src;
      if (deint_mode) src = (j % ROWS) * COLS + j / ROWS;   // R3
      else            src = (j % COLS) * ROWS + j / COLS;   // R2
      exp_sym_q.push_back(cur[src]);
      exp_sof_q.push_back(j == 0);
      exp_mode_q.push_back(deint_mode);
    end
    exp_cyc_q.push_back(cyc + 1);  // R4: one cycle after the accepting edge
  endtask

  task automatic send_sym(input bit s, input bit sof);
    bit exp_e;
    exp_e    = sof && (kidx != 0);
    in_sym   = s;
    in_valid = 1'b1;
    in_sof   = sof;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    check_bit(frame_err, exp_e, exp_e ? "R8" : "R10", "frame_err");
    if (sof) kidx = 0;
    cur[kidx] = s;
    kidx++;
    if (kidx == DEPTH) begin
      push_expected();
      kidx = 0;
    end
  endtask

  // Idle cycles with junk on the data and marker inputs (R10)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0;
      in_sof   = 1'b1;
      in_sym   = next_bit();
      @(posedge clk);
      @(negedge clk);
      in_sof = 1'b0;
      check_bit(frame_err, 1'b0, "R10", "frame_err on idle marker");
    end
  endtask

  task automatic send_frame(input int n, input bit gaps, input bit first_sof);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) idle(1);
      lfsr_bit = next_bit();
      send_sym(lfsr_bit, first_sof && (i == 0));
    end
  endtask

  task automatic drain();
    while (exp_sym_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Output monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (exp_sym_q.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R7 unexpected output actual=1 expected=0 (cycle %0d)", cyc);
        end else begin
          bit es, ef, em;
          es = exp_sym_q.pop_front();
          ef = exp_sof_q.pop_front();
          em = exp_mode_q.pop_front();
          check_bit(out_sym, es, em ? "R3" : "R2", "out_sym");
          check_bit(out_sof, ef, "R6", "out_sof");
          if (ef) check_int(cyc, exp_cyc_q.pop_front(), "R4", "first output cycle");
          out_idx = (out_idx + 1) % DEPTH;
        end
      end else if (out_idx != 0) begin
        check_bit(out_valid, 1'b1, "R6", "out_valid gap inside frame");
        out_idx = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected<%0d cycles", cyc, 100000);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; deint_mode = 1'b0; in_sym = 1'b0; in_valid = 1'b0; in_sof = 1'b0;
    repeat (5) @(negedge clk);
    check_bit(out_valid, 1'b0, "R9", "out_valid in reset");
    check_bit(out_sof,   1'b0, "R9", "out_sof in reset");
    check_bit(frame_err, 1'b0, "R9", "frame_err in reset");
    rst = 1'b0;
    @(negedge clk);

    // R7: one symbol short of a page, nothing may appear
    send_frame(DEPTH - 1, 1'b0, 1'b1);
    idle(20);
    check_bit(out_valid, 1'b0, "R7", "out_valid before first page");
    send_frame(1, 1'b0, 1'b0);

    // R5: back-to-back frames at full rate, swap meets last read
    send_frame(DEPTH, 1'b0, 1'b1);
    send_frame(DEPTH, 1'b0, 1'b0);
    // gapped frame with idle junk markers
    send_frame(DEPTH, 1'b1, 1'b1);
    drain();

    // R8: premature frame start drops the partial frame
    send_frame(100, 1'b0, 1'b1);
    send_frame(DEPTH, 1'b0, 1'b1);
    drain();

    // R3: inverse mapping
    deint_mode = 1'b1;
    send_frame(DEPTH, 1'b0, 1'b1);
    send_frame(DEPTH, 1'b0, 1'b1);
    send_frame(DEPTH, 1'b1, 1'b0);
    drain();

    // R1: every completed frame drained completely
    check_int(exp_sym_q.size(), 0, "R1", "pending expected symbols");
    check_int(exp_cyc_q.size(), 0, "R1", "pending frame starts");
    check_bit(out_valid, 1'b0, "R1", "out_valid after drain");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule